// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL clock waveform for an I2C master. A free-running prescaler divides the system clock by a power of two and emits one-cycle tick pulses. Everything else in the block advances on those ticks. Software programs three small registers: the prescaler select, the low-phase count and the high-phase count.

Each SCL phase lasts its programmed count plus a fixed overhead. The overhead is 4 ticks when the prescaler is undivided and 3 ticks otherwise. It stands in for the cycles that the input synchronizer and the glitch filter consume on a real bus.

The low phase is timed purely by the generator. The high phase begins counting only once the synchronized and filtered SCL input has been accepted as high. As a result, a target device holding SCL low stretches the clock, and short glitches on the line are ignored. The byte engine downstream receives the tick pulse and the SCL pull-down request.

Top module: `scl_rate_gen`

## Requirements
- R1: Out of reset, `scl_drive_low` is 0 and the prescaler select is 0, so `tick` pulses every cycle. The mode register reads 0x00, and the low-count and high-count registers each read 0xFF.
- R2: Mode register (address 0) bits 6:4 hold the prescaler select n. `tick` is a one-cycle pulse every 2^n clock cycles. A written value of 7 is stored as 6, and the field reads back at bits 6:4.
- R3: A mode write changes the prescaler select only when bit 3 of that same write is 1. Otherwise the stored select, and with it the tick spacing, is unchanged.
- R4: The low count (address 1) and the high count (address 2) are each stored from bits 4:0 of the write. A written 0 is stored as 1. Bits 7:5 read as 1. `rd_data` shows the register selected by `rd_addr` one cycle later.
- R5: The low phase asserts `scl_drive_low` for (L + K) * 2^n clock cycles, where L is the low count. K is 4 when n = 0 and 3 otherwise.
- R6: When no other device holds SCL, `scl_drive_low` stays deasserted for (H + K + 4) * 2^n clock cycles, where H is the high count. The extra 4 ticks are taken by the two-stage synchronizer and the two-tick filter.
- R7: While SCL is held low by another device after release, `scl_drive_low` stays deasserted. With n = 0 it reasserts exactly H + K + 4 cycles after SCL rises.
- R8: A level on SCL must be seen on 2 consecutive ticks before it is accepted. A high pulse of one cycle during a stretch (n = 0) does not start the high count.
- R9: Count registers are sampled at the start of each phase. A count write made during a phase leaves that phase unchanged and applies to the next phase of that kind.
- R10: While `en` is 0, `scl_drive_low` is 0 from the next cycle on. After `en` rises, the generator starts with a low phase at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the SCL waveform |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 low count, 2 high count |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| scl_in | input | 1 | SCL level seen on the bus |
| tick | output | 1 | Prescaled one-cycle enable pulse |
| scl_drive_low | output | 1 | Request to pull SCL low |

## Verification
The bench builds the block with its default parameters: 5-bit counts, a 3-bit select capped at 6, a two-stage synchronizer and a two-tick filter. These defaults make both overhead constants, the count extremes of 1 and 31, and the deepest division of 64 all reachable within a short run. The vector table sweeps these settings against hand-computed phase lengths in clock cycles. Undivided settings keep every tick on every clock, so the stretch and glitch tests can be timed to the exact cycle.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;

  localparam int MODE_SEL_LSB = 4;
  localparam int MODE_WREN_BIT = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;
endpackage

// File: rtl/scl_rate_regs.sv
module scl_rate_regs
  import scl_rate_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 5,
  parameter int PSEL_W   = 3,
  parameter int PSEL_MAX = 6,
  parameter int RST_CNT  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PSEL_W-1:0] psel,
  output logic [CNT_W-1:0]  lo_cnt,
  output logic [CNT_W-1:0]  hi_cnt,
  output logic              psel_wr
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [PSEL_W-1:0] sel_in;
  logic [CNT_W-1:0]  cnt_in;
  logic [DATA_W-1:0] mode_view;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    sel_in = wr_data[MODE_SEL_LSB +: PSEL_W];
    if (int'(sel_in) > PSEL_MAX) sel_in = PSEL_W'(PSEL_MAX);
    cnt_in = wr_data[CNT_W-1:0];
    if (cnt_in == '0) cnt_in = CNT_W'(1);
    mode_view = '0;
    mode_view[MODE_SEL_LSB +: PSEL_W] = psel;
  end

  assign psel_wr = wr_en && (wr_addr == ADDR_MODE) && wr_data[MODE_WREN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      psel    <= '0;
      lo_cnt  <= CNT_W'(RST_CNT);
      hi_cnt  <= CNT_W'(RST_CNT);
      rd_data <= '0;
    end else begin
      if (psel_wr) psel <= sel_in;
      if (wr_en && wr_addr == ADDR_LOW)  lo_cnt <= cnt_in;
      if (wr_en && wr_addr == ADDR_HIGH) hi_cnt <= cnt_in;
      case (rd_addr)
        ADDR_MODE: rd_data <= mode_view;
        ADDR_LOW:  rd_data <= {{PAD_W{1'b1}}, lo_cnt};
        ADDR_HIGH: rd_data <= {{PAD_W{1'b1}}, hi_cnt};
        default:   rd_data <= '0;
      endcase
    end
  end

  assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt != '0) && (hi_cnt != '0));
  assert_sel_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(psel) <= PSEL_MAX);
  assert_sel_protect_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_MODE && !wr_data[MODE_WREN_BIT]) |=> $stable(psel));
endmodule

// File: rtl/scl_rate_presc.sv
module scl_rate_presc #(
  parameter int PSEL_W   = 3,
  parameter int PSEL_MAX = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PSEL_W-1:0] psel,
  input  logic              restart,
  output logic              tick
);
  localparam int PRE_W = (PSEL_MAX < 1) ? 1 : PSEL_MAX;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  always_comb mask = PRE_W'((32'd1 << psel) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      pre_cnt <= restart ? '0 : pre_cnt + PRE_W'(1);
      tick    <= !restart && ((pre_cnt & mask) == mask);
    end
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && psel != '0) |=> !tick);
endmodule

// File: rtl/scl_rate_filter.sv
module scl_rate_filter #(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic scl_in,
  output logic level,
  output logic rise
);
  localparam int RUN_W = $clog2(FILT_N + 1);

  logic [SYNC_N-1:0] sync_q;
  logic [RUN_W-1:0]  run_q;
  logic              samp, mism, accept;

  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) sync_q[i] <= 1'b1;
        else if (tick) sync_q[i] <= scl_in;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) sync_q[i] <= 1'b1;
        else if (tick) sync_q[i] <= sync_q[i-1];
    end
  end

  assign samp   = sync_q[SYNC_N-1];
  assign mism   = samp != level;
  assign accept = tick && mism && (run_q == RUN_W'(FILT_N - 1));
  assign rise   = accept && samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b1;
      run_q <= '0;
    end else if (tick) begin
      if (!mism) run_q <= '0;
      else if (accept) begin
        level <= samp;
        run_q <= '0;
      end else run_q <= run_q + RUN_W'(1);
    end
  end

  assert_level_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level));
  assert_run_bound_R8: assert property (@(posedge clk) disable iff (rst)
    int'(run_q) < FILT_N);
endmodule

// File: rtl/scl_rate_phase.sv
module scl_rate_phase
  import scl_rate_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int PSEL_W    = 3,
  parameter int OVH_UNDIV = 4,
  parameter int OVH_DIV   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [PSEL_W-1:0] psel,
  input  logic [CNT_W-1:0]  lo_cnt,
  input  logic [CNT_W-1:0]  hi_cnt,
  input  logic              scl_high,
  input  logic              scl_rise,
  output logic              drive_low
);
  localparam int LEN_MAX = (1 << CNT_W) - 1 + OVH_UNDIV;
  localparam int LEN_W   = $clog2(LEN_MAX + 1);

  phase_t           state;
  logic [LEN_W-1:0] cnt, ovh, lo_len, hi_len;

  always_comb begin
    ovh    = (psel == '0) ? LEN_W'(OVH_UNDIV) : LEN_W'(OVH_DIV);
    lo_len = LEN_W'(lo_cnt) + ovh;
    hi_len = LEN_W'(hi_cnt) + ovh;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= PH_IDLE;
      drive_low <= 1'b0;
      cnt       <= '0;
    end else if (tick) begin
      case (state)
        PH_IDLE: begin
          state     <= PH_LOW;
          drive_low <= 1'b1;
          cnt       <= lo_len - LEN_W'(1);
        end
        PH_LOW: begin
          if (cnt == '0) begin
            state     <= PH_WAIT;
            drive_low <= 1'b0;
          end else cnt <= cnt - LEN_W'(1);
        end
        PH_WAIT: begin
          if (scl_high || scl_rise) begin
            state <= PH_HIGH;
            cnt   <= hi_len - LEN_W'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            state     <= PH_LOW;
            drive_low <= 1'b1;
            cnt       <= lo_len - LEN_W'(1);
          end else cnt <= cnt - LEN_W'(1);
        end
      endcase
    end
  end

  assert_drive_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick && en) |=> $stable(drive_low));
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= LEN_MAX);
  assert_wait_released_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PH_WAIT) |-> !drive_low);
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !drive_low);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 5,
  parameter int PSEL_W    = 3,
  parameter int PSEL_MAX  = 6,
  parameter int RST_CNT   = 31,
  parameter int OVH_UNDIV = 4,
  parameter int OVH_DIV   = 3,
  parameter int SYNC_N    = 2,
  parameter int FILT_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              scl_in,
  output logic              tick,
  output logic              scl_drive_low
);
  logic [PSEL_W-1:0] psel;
  logic [CNT_W-1:0]  lo_cnt, hi_cnt;
  logic              psel_wr, scl_level, scl_rise;

  scl_rate_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PSEL_W(PSEL_W),
    .PSEL_MAX(PSEL_MAX), .RST_CNT(RST_CNT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .psel(psel), .lo_cnt(lo_cnt),
    .hi_cnt(hi_cnt), .psel_wr(psel_wr)
  );

  scl_rate_presc #(.PSEL_W(PSEL_W), .PSEL_MAX(PSEL_MAX)) u_presc (
    .clk(clk), .rst(rst), .psel(psel), .restart(psel_wr), .tick(tick)
  );

  scl_rate_filter #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_filter (
    .clk(clk), .rst(rst), .tick(tick), .scl_in(scl_in),
    .level(scl_level), .rise(scl_rise)
  );

  scl_rate_phase #(
    .CNT_W(CNT_W), .PSEL_W(PSEL_W), .OVH_UNDIV(OVH_UNDIV), .OVH_DIV(OVH_DIV)
  ) u_phase (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .psel(psel),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .scl_high(scl_level),
    .scl_rise(scl_rise), .drive_low(scl_drive_low)
  );
endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       tick, drv;
  logic       hold = 1'b0;
  wire        scl_line = !(drv || hold);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  scl_rate_gen u_scl_rate_gen (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .scl_in(scl_line), .tick(tick), .scl_drive_low(drv)
  );

  // {select, low count written, high count written, low cycles, released cycles}
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{0,  1,  1,   5,   9},
    '{0, 10,  6,  14,  14},
    '{1,  2,  3,  10,  20},
    '{2,  5,  1,  32,  32},
    '{3, 31, 31, 272, 304},
    '{0, 31,  2,  35,  10},
    '{6,  1,  1, 256, 512},
    '{0,  0,  3,   5,  11}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic wait_drv(input logic v, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (drv !== v);
  endtask

  task automatic tick_gap(output int n);
    while (tick !== 1'b1) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (tick !== 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int d, lo, hi, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(drv == 1'b0, "R1 drive", int'(drv), 0);
    rd(2'd0, d); check(d == 8'h00, "R1 mode", d, 8'h00);
    rd(2'd1, d); check(d == 8'hFF, "R1 low", d, 8'hFF);
    rd(2'd2, d); check(d == 8'hFF, "R1 high", d, 8'hFF);
    tick_gap(d); check(d == 1, "R1 tick gap", d, 1);

    // R10: disabled keeps line released, start is a low phase at next tick
    bad = 0;
    repeat (100) begin @(negedge clk); if (drv) bad++; end
    check(bad == 0, "R10 idle released", bad, 0);
    en = 1'b1;
    wait_drv(1'b1, d); check(d == 1, "R10 start", d, 1);

    // R3: write without bit 3 is ignored
    wr(2'd0, 8'h50);
    rd(2'd0, d); check(d == 8'h00, "R3 protect", d, 8'h00);
    tick_gap(d); check(d == 1, "R3 tick gap", d, 1);

    // R2: select 7 stored as 6
    wr(2'd0, 8'h78);
    rd(2'd0, d); check(d == 8'h60, "R2 clamp", d, 8'h60);
    tick_gap(d); check(d == 64, "R2 tick gap 64", d, 64);

    // R4: count fields
    wr(2'd1, 8'h00);
    rd(2'd1, d); check(d == 8'hE1, "R4 zero as one", d, 8'hE1);
    wr(2'd2, 8'hAA);
    rd(2'd2, d); check(d == 8'hEA, "R4 high field", d, 8'hEA);

    // R5 R6 R2: vector sweep
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 8'((VEC[i][0] << 4) | 8));
      wr(2'd1, 8'(VEC[i][1]));
      wr(2'd2, 8'(VEC[i][2]));
      tick_gap(d);
      check(d == (1 << VEC[i][0]), "R2 tick gap", d, 1 << VEC[i][0]);
      wait_drv(1'b0, d);
      wait_drv(1'b1, d);
      wait_drv(1'b0, lo);
      wait_drv(1'b1, hi);
      check(lo == VEC[i][3], "R5 low length", lo, VEC[i][3]);
      check(hi == VEC[i][4], "R6 high length", hi, VEC[i][4]);
    end

    // R9: count change applies to the next phase only
    wr(2'd0, 8'h08);
    wr(2'd1, 8'd10);
    wr(2'd2, 8'd6);
    wait_drv(1'b0, d);
    wait_drv(1'b1, d);
    wr(2'd1, 8'd20);
    wait_drv(1'b0, lo);
    check(lo + 1 == 14, "R9 current low", lo + 1, 14);
    wait_drv(1'b1, hi);
    check(hi == 14, "R9 high", hi, 14);
    wait_drv(1'b0, lo);
    check(lo == 24, "R9 next low", lo, 24);

    // R7 R8: stretch with a glitch
    wr(2'd1, 8'd10);
    wait_drv(1'b1, d);
    hold = 1'b1;
    wait_drv(1'b0, d);
    bad = 0;
    repeat (50) begin @(negedge clk); if (drv) bad++; end
    check(bad == 0, "R7 stretch held", bad, 0);
    hold = 1'b0;
    @(negedge clk);
    hold = 1'b1;
    bad = 0;
    repeat (20) begin @(negedge clk); if (drv) bad++; end
    check(bad == 0, "R8 glitch ignored", bad, 0);
    hold = 1'b0;
    wait_drv(1'b1, d);
    check(d == 14, "R7 after stretch", d, 14);

    // R10: dropping enable releases the line next cycle
    en = 1'b0;
    @(negedge clk);
    check(drv == 1'b0, "R10 disable", int'(drv), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule